// File: doc/BRIEF.md
# Trap Entry Sequencer

This block is the trap-entry stage of a small 32-bit in-order core with a branch delay slot. Each cycle it may see up to four request lines: a memory-management fault, a hardware break, a software break and an external interrupt. It picks one cause by fixed priority and checks that the cause may be taken. On the next clock edge it commits every architectural side effect of the entry together. These are the machine status word, the exception status word, the faulting address, the saved branch target, the link-register write and the new fetch address.

The core supplies the current PC, the branch target, its instruction-state flags and, for a memory fault, the faulting address, whether the fault was a protection fault or a missing translation, and the access type. The core's own status-register writes come in through a write port, and the current values of the status registers are visible on the outputs. For one cycle after each accepted entry, the block reports the new PC, the link write and a request to clear the core's delay-slot and prefix flags. A memory fault that arrives while a previous one is still being handled raises a fatal flag instead of being taken.

Top module: `exc_entry_seq`

## Requirements
- R1: An accepted entry jumps to a fixed address per cause. A memory fault goes to 0x20, an interrupt to 0x10 and a hardware break to 0x18. A software break goes to the branch target input.
- R2: The return address goes to link register 17 for a memory fault, 14 for an interrupt and 16 for a hardware break. A software break writes no link register (`link_we_o` low).
- R3: On every accepted entry, the user-mode bit 11 is moved into bit 12 and the virtual-memory bit 13 is moved into bit 14 of the status word. Bits 11 and 13 end cleared, and the earlier contents of bits 12 and 14 are lost.
- R4: An interrupt clears the interrupt-enable bit 1. A memory fault sets the exception-active bit 9. Both break causes set the break-active bit 3. All other status bits outside bits 11 to 14 keep their values.
- R5: A memory fault writes the exception status word. Bits 4:0 hold 16 for a protection fault (`fault_miss_i`=0) or 18 for a missing translation (`fault_miss_i`=1), plus one when the access was an instruction fetch (`fault_acc_i`=2). Bit 10 is set for a store (`fault_acc_i`=1), and all other bits except bit 12 are zero. No other cause changes this word.
- R6: A memory fault taken with the delay-slot flag set sets exception-status bit 12 and copies the branch target into the saved-target register. The return address is the PC minus 4, or the PC minus 8 when the prefixed-branch flag is also set. The delay-slot flag takes precedence over the prefix flag.
- R7: A memory fault with only the prefix flag set saves the PC minus 4. With neither flag set, it saves the PC. Interrupts and hardware breaks always save the PC unchanged.
- R8: A memory fault captures the faulting address and asserts `clr_iflags_o`. The saved-target register changes only in the R6 case, and the faulting address register changes only on a memory fault.
- R9: A memory fault request while bit 9 is set pulses `fatal_o` in the next cycle. Nothing is accepted in that cycle, and all registers keep their values.
- R10: An interrupt is accepted only when bit 1 is set, bits 9 and 3 are clear and the delay-slot flag is clear. Otherwise it is ignored, with no change to any output register.
- R11: Simultaneous requests are served in the order memory fault, hardware break, software break, interrupt. `cause_o` reports 0 for a memory fault, 1 for an interrupt, 2 for a software break and 3 for a hardware break.
- R12: After reset the status word is zero and `take_o`, `fatal_o` and `link_we_o` are low. Results appear one cycle after the request, and `take_o` is a single-cycle pulse. A status write from the core updates the status word when no entry is accepted, and is discarded when one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mmu_i | input | 1 | Memory-management fault request |
| req_hwbrk_i | input | 1 | Hardware break request |
| req_swbrk_i | input | 1 | Software break request |
| req_irq_i | input | 1 | External interrupt request |
| pc_i | input | DATA_W | PC of the current instruction |
| btarget_i | input | DATA_W | Pending branch target |
| dslot_i | input | 1 | Instruction is in a branch delay slot |
| imm_i | input | 1 | Instruction follows an immediate prefix |
| bimm_i | input | 1 | The delayed branch itself was prefixed |
| fault_addr_i | input | DATA_W | Faulting data or fetch address |
| fault_miss_i | input | 1 | 1: missing translation, 0: protection fault |
| fault_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| msr_wr_en_i | input | 1 | Core write to the status word |
| msr_wr_data_i | input | DATA_W | Data for the status word write |
| take_o | output | 1 | Entry accepted last cycle (one-cycle pulse) |
| cause_o | output | 2 | Cause of the last accepted entry |
| pc_o | output | DATA_W | New fetch address |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | REG_IDX_W | Link register index |
| link_data_o | output | DATA_W | Return address for the link register |
| clr_iflags_o | output | 1 | Clear the delay-slot and prefix flags |
| msr_o | output | DATA_W | Current status word |
| esr_o | output | DATA_W | Current exception status word |
| ear_o | output | DATA_W | Current faulting address register |
| btr_o | output | DATA_W | Current saved branch target |
| fatal_o | output | 1 | Recursive memory fault detected |

## Verification
A corrupted status word shows up at once on `msr_o`. It also shows at the next interrupt request, which is then wrongly accepted or refused, and at the next memory fault, which is then wrongly flagged as fatal. A wrong return rewind or a wrong fault code is visible on `link_data_o` and `esr_o` in the cycle right after the request. The sweeps pair every flag and access combination with a different PC and status pattern, so a swapped bit or an offset error shows up in that one cycle rather than much later.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [1:0] {
    CAUSE_MMU   = 2'd0,
    CAUSE_IRQ   = 2'd1,
    CAUSE_SWBRK = 2'd2,
    CAUSE_HWBRK = 2'd3
  } cause_e;

  // status word bit positions; each saved copy sits one above its live bit
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  // exception status word fields
  localparam int ESR_CODE_W    = 5;
  localparam int ESR_STORE_BIT = 10;
  localparam int ESR_DSLOT_BIT = 12;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic   req_mmu,
  input  logic   req_hwbrk,
  input  logic   req_swbrk,
  input  logic   req_irq,
  input  logic   msr_ie,
  input  logic   msr_eip,
  input  logic   msr_bip,
  input  logic   dslot,
  output logic   accept,
  output cause_e cause,
  output logic   fatal
);

  logic irq_allowed;

  assign irq_allowed = req_irq & msr_ie & ~msr_eip & ~msr_bip & ~dslot;

  always_comb begin
    accept = 1'b0;
    cause  = CAUSE_MMU;
    fatal  = 1'b0;
    if (req_mmu) begin
      if (msr_eip) begin
        fatal = 1'b1;
      end else begin
        accept = 1'b1;
        cause  = CAUSE_MMU;
      end
    end else if (req_hwbrk) begin
      accept = 1'b1;
      cause  = CAUSE_HWBRK;
    end else if (req_swbrk) begin
      accept = 1'b1;
      cause  = CAUSE_SWBRK;
    end else if (irq_allowed) begin
      accept = 1'b1;
      cause  = CAUSE_IRQ;
    end
  end

endmodule

// File: rtl/exc_target_sel.sv
module exc_target_sel
  import exc_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_IDX_W  = 5,
  parameter int INSN_BYTES = 4,
  parameter int VEC_MMU    = 'h20,
  parameter int VEC_IRQ    = 'h10,
  parameter int VEC_HWBRK  = 'h18,
  parameter int LINK_MMU   = 17,
  parameter int LINK_IRQ   = 14,
  parameter int LINK_HWBRK = 16
) (
  input  cause_e                cause,
  input  logic [DATA_W-1:0]     pc,
  input  logic [DATA_W-1:0]     btarget,
  input  logic                  dslot,
  input  logic                  imm,
  input  logic                  bimm,
  output logic [DATA_W-1:0]     new_pc,
  output logic                  link_we,
  output logic [REG_IDX_W-1:0]  link_idx,
  output logic [DATA_W-1:0]     link_data
);

  localparam logic [DATA_W-1:0] STEP1 = DATA_W'(INSN_BYTES);
  localparam logic [DATA_W-1:0] STEP2 = DATA_W'(2 * INSN_BYTES);

  logic [DATA_W-1:0] rewind;

  // how far back the return address must point so the interrupted
  // branch or prefix is re-executed
  always_comb begin
    if (dslot)     rewind = bimm ? STEP2 : STEP1;
    else if (imm)  rewind = STEP1;
    else           rewind = '0;
  end

  always_comb begin
    new_pc    = btarget;
    link_we   = 1'b0;
    link_idx  = '0;
    link_data = pc;
    unique case (cause)
      CAUSE_MMU: begin
        new_pc    = DATA_W'(VEC_MMU);
        link_we   = 1'b1;
        link_idx  = REG_IDX_W'(LINK_MMU);
        link_data = pc - rewind;
      end
      CAUSE_IRQ: begin
        new_pc   = DATA_W'(VEC_IRQ);
        link_we  = 1'b1;
        link_idx = REG_IDX_W'(LINK_IRQ);
      end
      CAUSE_HWBRK: begin
        new_pc   = DATA_W'(VEC_HWBRK);
        link_we  = 1'b1;
        link_idx = REG_IDX_W'(LINK_HWBRK);
      end
      default: begin
        new_pc  = btarget;
        link_we = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/exc_status_next.sv
module exc_status_next
  import exc_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cause_e            cause,
  input  logic [DATA_W-1:0] msr_q,
  input  logic [DATA_W-1:0] esr_q,
  input  logic [DATA_W-1:0] ear_q,
  input  logic [DATA_W-1:0] btr_q,
  input  logic              dslot,
  input  logic [DATA_W-1:0] btarget,
  input  logic [DATA_W-1:0] fault_addr,
  input  logic              fault_miss,
  input  logic [1:0]        fault_acc,
  output logic [DATA_W-1:0] msr_n,
  output logic [DATA_W-1:0] esr_n,
  output logic [DATA_W-1:0] ear_n,
  output logic [DATA_W-1:0] btr_n
);

  logic                  is_fetch;
  logic                  is_store;
  logic [ESR_CODE_W-1:0] fault_code;

  assign is_fetch   = (fault_acc == ACC_FETCH);
  assign is_store   = (fault_acc == ACC_STORE);
  // 16 protection, 18 missing translation, +1 for instruction fetch
  assign fault_code = {3'b100, fault_miss, is_fetch};

  always_comb begin
    msr_n = msr_q;
    esr_n = esr_q;
    ear_n = ear_q;
    btr_n = btr_q;

    msr_n[MSR_VMS] = msr_q[MSR_VM];
    msr_n[MSR_UMS] = msr_q[MSR_UM];
    msr_n[MSR_VM]  = 1'b0;
    msr_n[MSR_UM]  = 1'b0;

    unique case (cause)
      CAUSE_MMU: begin
        msr_n[MSR_EIP]       = 1'b1;
        esr_n                = '0;
        esr_n[ESR_CODE_W-1:0] = fault_code;
        esr_n[ESR_STORE_BIT] = is_store;
        esr_n[ESR_DSLOT_BIT] = dslot;
        ear_n                = fault_addr;
        if (dslot) btr_n = btarget;
      end
      CAUSE_IRQ: begin
        msr_n[MSR_IE] = 1'b0;
      end
      default: begin
        msr_n[MSR_BIP] = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_IDX_W  = 5,
  parameter int INSN_BYTES = 4,
  parameter int VEC_MMU    = 'h20,
  parameter int VEC_IRQ    = 'h10,
  parameter int VEC_HWBRK  = 'h18,
  parameter int LINK_MMU   = 17,
  parameter int LINK_IRQ   = 14,
  parameter int LINK_HWBRK = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_mmu_i,
  input  logic                 req_hwbrk_i,
  input  logic                 req_swbrk_i,
  input  logic                 req_irq_i,
  input  logic [DATA_W-1:0]    pc_i,
  input  logic [DATA_W-1:0]    btarget_i,
  input  logic                 dslot_i,
  input  logic                 imm_i,
  input  logic                 bimm_i,
  input  logic [DATA_W-1:0]    fault_addr_i,
  input  logic                 fault_miss_i,
  input  logic [1:0]           fault_acc_i,
  input  logic                 msr_wr_en_i,
  input  logic [DATA_W-1:0]    msr_wr_data_i,
  output logic                 take_o,
  output logic [1:0]           cause_o,
  output logic [DATA_W-1:0]    pc_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [DATA_W-1:0]    link_data_o,
  output logic                 clr_iflags_o,
  output logic [DATA_W-1:0]    msr_o,
  output logic [DATA_W-1:0]    esr_o,
  output logic [DATA_W-1:0]    ear_o,
  output logic [DATA_W-1:0]    btr_o,
  output logic                 fatal_o
);

  // architectural state
  logic [DATA_W-1:0]    msr_q, msr_d;
  logic [DATA_W-1:0]    esr_q, esr_d;
  logic [DATA_W-1:0]    ear_q, ear_d;
  logic [DATA_W-1:0]    btr_q, btr_d;
  // entry result, valid for one cycle after accept
  logic                 take_q, take_d;
  logic [1:0]           cause_q, cause_d;
  logic [DATA_W-1:0]    pc_q, pc_d;
  logic                 lwe_q, lwe_d;
  logic [REG_IDX_W-1:0] lidx_q, lidx_d;
  logic [DATA_W-1:0]    ldat_q, ldat_d;
  logic                 clr_q, clr_d;
  logic                 fatal_q, fatal_d;

  logic                 accept;
  cause_e               cause;
  logic                 fatal;
  logic [DATA_W-1:0]    tgt_pc;
  logic                 tgt_lwe;
  logic [REG_IDX_W-1:0] tgt_lidx;
  logic [DATA_W-1:0]    tgt_ldat;
  logic [DATA_W-1:0]    st_msr, st_esr, st_ear, st_btr;

  exc_arbiter u_arb (
    .req_mmu   (req_mmu_i),
    .req_hwbrk (req_hwbrk_i),
    .req_swbrk (req_swbrk_i),
    .req_irq   (req_irq_i),
    .msr_ie    (msr_q[MSR_IE]),
    .msr_eip   (msr_q[MSR_EIP]),
    .msr_bip   (msr_q[MSR_BIP]),
    .dslot     (dslot_i),
    .accept    (accept),
    .cause     (cause),
    .fatal     (fatal)
  );

  exc_target_sel #(
    .DATA_W     (DATA_W),
    .REG_IDX_W  (REG_IDX_W),
    .INSN_BYTES (INSN_BYTES),
    .VEC_MMU    (VEC_MMU),
    .VEC_IRQ    (VEC_IRQ),
    .VEC_HWBRK  (VEC_HWBRK),
    .LINK_MMU   (LINK_MMU),
    .LINK_IRQ   (LINK_IRQ),
    .LINK_HWBRK (LINK_HWBRK)
  ) u_tgt (
    .cause     (cause),
    .pc        (pc_i),
    .btarget   (btarget_i),
    .dslot     (dslot_i),
    .imm       (imm_i),
    .bimm      (bimm_i),
    .new_pc    (tgt_pc),
    .link_we   (tgt_lwe),
    .link_idx  (tgt_lidx),
    .link_data (tgt_ldat)
  );

  exc_status_next #(
    .DATA_W (DATA_W)
  ) u_st (
    .cause      (cause),
    .msr_q      (msr_q),
    .esr_q      (esr_q),
    .ear_q      (ear_q),
    .btr_q      (btr_q),
    .dslot      (dslot_i),
    .btarget    (btarget_i),
    .fault_addr (fault_addr_i),
    .fault_miss (fault_miss_i),
    .fault_acc  (fault_acc_i),
    .msr_n      (st_msr),
    .esr_n      (st_esr),
    .ear_n      (st_ear),
    .btr_n      (st_btr)
  );

  // next-state
  always_comb begin
    msr_d   = msr_q;
    esr_d   = esr_q;
    ear_d   = ear_q;
    btr_d   = btr_q;
    cause_d = cause_q;
    pc_d    = pc_q;
    lidx_d  = lidx_q;
    ldat_d  = ldat_q;
    take_d  = accept;
    lwe_d   = accept & tgt_lwe;
    clr_d   = accept & (cause == CAUSE_MMU);
    fatal_d = fatal;
    if (accept) begin
      msr_d   = st_msr;
      esr_d   = st_esr;
      ear_d   = st_ear;
      btr_d   = st_btr;
      cause_d = cause;
      pc_d    = tgt_pc;
      lidx_d  = tgt_lidx;
      ldat_d  = tgt_ldat;
    end else if (msr_wr_en_i) begin
      msr_d = msr_wr_data_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_q   <= '0;
      esr_q   <= '0;
      ear_q   <= '0;
      btr_q   <= '0;
      take_q  <= 1'b0;
      cause_q <= '0;
      pc_q    <= '0;
      lwe_q   <= 1'b0;
      lidx_q  <= '0;
      ldat_q  <= '0;
      clr_q   <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      msr_q   <= msr_d;
      esr_q   <= esr_d;
      ear_q   <= ear_d;
      btr_q   <= btr_d;
      take_q  <= take_d;
      cause_q <= cause_d;
      pc_q    <= pc_d;
      lwe_q   <= lwe_d;
      lidx_q  <= lidx_d;
      ldat_q  <= ldat_d;
      clr_q   <= clr_d;
      fatal_q <= fatal_d;
    end
  end

  assign take_o       = take_q;
  assign cause_o      = cause_q;
  assign pc_o         = pc_q;
  assign link_we_o    = lwe_q;
  assign link_idx_o   = lidx_q;
  assign link_data_o  = ldat_q;
  assign clr_iflags_o = clr_q;
  assign msr_o        = msr_q;
  assign esr_o        = esr_q;
  assign ear_o        = ear_q;
  assign btr_o        = btr_q;
  assign fatal_o      = fatal_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int DATA_W  = 32,
  parameter int VEC_MMU = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_mmu_i,
  input logic              msr_wr_en_i,
  input logic              take_o,
  input logic [1:0]        cause_o,
  input logic [DATA_W-1:0] pc_o,
  input logic              link_we_o,
  input logic [DATA_W-1:0] msr_o,
  input logic              fatal_o
);

  // R1, R11: a legal memory fault is always taken next cycle at its vector
  a_r1_mmu_vector: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu_i && !msr_o[9] |=> take_o && cause_o == 2'd0 && pc_o == DATA_W'(VEC_MMU));

  // R9: nested memory fault is fatal and takes nothing
  a_r9_recursive: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu_i && msr_o[9] |=> fatal_o && !take_o);

  // R3: live mode bits move into their saved copies
  a_r3_mode_save: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> msr_o[14] == $past(msr_o[13]) && msr_o[12] == $past(msr_o[11])
               && !msr_o[13] && !msr_o[11]);

  // R4: an interrupt was taken only with enable set, and it clears enable
  a_r4_irq_ie: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && cause_o == 2'd1 |-> !msr_o[1] && $past(msr_o[1]));

  // R2: software break never writes a link register
  a_r2_swbrk_nolink: assert property (@(posedge clk) disable iff (!rst_n)
    take_o && cause_o == 2'd2 |-> !link_we_o);

  // R12: status word moves only on an entry or a core write
  a_r12_msr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o && !$past(msr_wr_en_i) |-> $stable(msr_o));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .DATA_W  (DATA_W),
  .VEC_MMU (VEC_MMU)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_mmu_i   (req_mmu_i),
  .msr_wr_en_i (msr_wr_en_i),
  .take_o      (take_o),
  .cause_o     (cause_o),
  .pc_o        (pc_o),
  .link_we_o   (link_we_o),
  .msr_o       (msr_o),
  .fatal_o     (fatal_o)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_mmu, req_hw, req_sw, req_irq;
  logic [31:0] pc, bt, faddr, wdata;
  logic        dsl, imm, bimm, fmiss, wen;
  logic [1:0]  facc;
  logic        take, lwe, clr, fatal;
  logic [1:0]  cause;
  logic [31:0] npc, ldat, msr, esr, ear, btr;
  logic [4:0]  lidx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] p, e_esr, e_ear, e_btr;

  always #4 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk (clk), .rst_n (rst_n),
    .req_mmu_i (req_mmu), .req_hwbrk_i (req_hw), .req_swbrk_i (req_sw), .req_irq_i (req_irq),
    .pc_i (pc), .btarget_i (bt), .dslot_i (dsl), .imm_i (imm), .bimm_i (bimm),
    .fault_addr_i (faddr), .fault_miss_i (fmiss), .fault_acc_i (facc),
    .msr_wr_en_i (wen), .msr_wr_data_i (wdata),
    .take_o (take), .cause_o (cause), .pc_o (npc), .link_we_o (lwe),
    .link_idx_o (lidx), .link_data_o (ldat), .clr_iflags_o (clr),
    .msr_o (msr), .esr_o (esr), .ear_o (ear), .btr_o (btr), .fatal_o (fatal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request cycle; returns after the registered result is visible
  task automatic step(input logic m, input logic h, input logic s, input logic q,
                      input logic we = 1'b0, input logic [31:0] wd = 32'h0);
    @(negedge clk);
    req_mmu = m; req_hw = h; req_sw = s; req_irq = q; wen = we; wdata = wd;
    @(negedge clk);
    req_mmu = 0; req_hw = 0; req_sw = 0; req_irq = 0; wen = 0;
  endtask

  task automatic set_msr(input logic [31:0] v);
    step(0, 0, 0, 0, 1'b1, v);
  endtask

  function automatic logic [31:0] mode_save(input logic [31:0] m);
    return (m & ~32'h0000_7800) | ((m & 32'h0000_2800) << 1);
  endfunction

  function automatic logic [31:0] exp_esr();
    logic [31:0] c;
    c = (fmiss ? 32'd18 : 32'd16) + ((facc == 2'd2) ? 32'd1 : 32'd0);
    if (facc == 2'd1) c = c | 32'h400;
    if (dsl)          c = c | 32'h1000;
    return c;
  endfunction

  function automatic logic [31:0] exp_link();
    if (dsl) return bimm ? pc - 32'd8 : pc - 32'd4;
    if (imm) return pc - 32'd4;
    return pc;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; req_mmu = 0; req_hw = 0; req_sw = 0; req_irq = 0;
    pc = 0; bt = 0; faddr = 0; wdata = 0; dsl = 0; imm = 0; bimm = 0;
    fmiss = 0; facc = 0; wen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 reset msr", msr, 32'h0);
    chk("R12 reset take", {31'h0, take}, 32'h0);
    chk("R12 reset fatal", {31'h0, fatal}, 32'h0);
    chk("R12 reset link_we", {31'h0, lwe}, 32'h0);
    e_esr = 0; e_ear = 0; e_btr = 0;

    // R1 R2 R3 R4 R5 R6 R7 R8: every fault kind, access and flag combination
    for (int i = 0; i < 48; i++) begin
      fmiss = (i % 2) != 0;
      facc  = 2'((i / 2) % 3);
      dsl   = ((i / 6) % 2) != 0;
      imm   = ((i / 12) % 2) != 0;
      bimm  = ((i / 24) % 2) != 0;
      pc    = 32'h0000_1000 + 32'(i) * 32'd16;
      bt    = 32'h8000_0000 ^ (32'(i) << 4);
      faddr = 32'hA000_0000 + 32'(i) * 32'h111;
      p     = ((32'(i) * 32'h0000_2A13) ^ 32'h0000_5000) & ~32'h0000_0200;
      set_msr(p);
      step(1, 0, 0, 0);
      chk("R1 mmu take", {31'h0, take}, 32'h1);
      chk("R11 mmu cause", {30'h0, cause}, 32'h0);
      chk("R1 mmu vector", npc, 32'h20);
      chk("R2 mmu link_we", {31'h0, lwe}, 32'h1);
      chk("R2 mmu link idx", {27'h0, lidx}, 32'd17);
      chk("R6 R7 mmu return address", ldat, exp_link());
      chk("R8 mmu clear flags", {31'h0, clr}, 32'h1);
      chk("R3 R4 mmu msr", msr, mode_save(p) | 32'h200);
      e_esr = exp_esr();
      e_ear = faddr;
      if (dsl) e_btr = bt;
      chk("R5 R6 mmu esr", esr, e_esr);
      chk("R8 mmu ear", ear, e_ear);
      chk("R6 R8 mmu btr", btr, e_btr);
      chk("R9 no fatal", {31'h0, fatal}, 32'h0);
    end
    @(negedge clk);
    chk("R12 take single pulse", {31'h0, take}, 32'h0);
    chk("R8 clear single pulse", {31'h0, clr}, 32'h0);

    // R10: interrupt gating over enable, exception-active, break-active, delay slot
    imm = 0; bimm = 0;
    for (int j = 0; j < 16; j++) begin
      logic ok;
      p = ((j % 2) != 0 ? 32'h2 : 32'h0) | (((j / 2) % 2) != 0 ? 32'h200 : 32'h0)
        | (((j / 4) % 2) != 0 ? 32'h8 : 32'h0) | ((32'(j) * 32'h0000_0C00) & 32'h0000_7800);
      dsl = ((j / 8) % 2) != 0;
      pc  = 32'h0000_4000 + 32'(j) * 32'd4;
      ok  = ((j % 2) != 0) && ((j / 2) % 2 == 0) && ((j / 4) % 2 == 0) && !dsl;
      set_msr(p);
      step(0, 0, 0, 1);
      chk("R10 irq take", {31'h0, take}, {31'h0, ok});
      chk("R9 irq no fatal", {31'h0, fatal}, 32'h0);
      if (ok) begin
        chk("R1 irq vector", npc, 32'h10);
        chk("R2 irq link idx", {27'h0, lidx}, 32'd14);
        chk("R7 irq link data", ldat, pc);
        chk("R11 irq cause", {30'h0, cause}, 32'h1);
        chk("R3 R4 irq msr", msr, mode_save(p) & ~32'h2);
        chk("R8 irq no clear", {31'h0, clr}, 32'h0);
      end else begin
        chk("R10 refused msr", msr, p);
        chk("R10 refused link_we", {31'h0, lwe}, 32'h0);
      end
      chk("R5 irq esr kept", esr, e_esr);
      chk("R8 irq ear kept", ear, e_ear);
    end

    // R1 R2 R4: hardware and software breaks
    dsl = 0;
    for (int k = 0; k < 8; k++) begin
      logic hw;
      hw = (k % 2) != 0;
      p  = (32'(k) * 32'h0000_0A05) & 32'h0000_7FFF;
      pc = 32'h0000_6000 + 32'(k) * 32'd8;
      bt = 32'h0003_0000 + 32'(k) * 32'h40;
      set_msr(p);
      step(0, hw, !hw, 0);
      chk("R1 break take", {31'h0, take}, 32'h1);
      chk("R11 break cause", {30'h0, cause}, hw ? 32'd3 : 32'd2);
      chk("R1 break vector", npc, hw ? 32'h18 : bt);
      chk("R2 break link_we", {31'h0, lwe}, {31'h0, hw});
      if (hw) begin
        chk("R2 hw link idx", {27'h0, lidx}, 32'd16);
        chk("R7 hw link data", ldat, pc);
      end
      chk("R3 R4 break msr", msr, mode_save(p) | 32'h8);
      chk("R5 break esr kept", esr, e_esr);
      chk("R8 break ear kept", ear, e_ear);
      chk("R8 break btr kept", btr, e_btr);
    end

    // R11: every combination of simultaneous requests
    for (int m = 1; m < 16; m++) begin
      logic [31:0] ec;
      ec = (m % 2) != 0 ? 32'd0 : ((m / 2) % 2) != 0 ? 32'd3 : ((m / 4) % 2) != 0 ? 32'd2 : 32'd1;
      fmiss = 1; facc = 0; faddr = 32'hC000_0000 + 32'(m);
      set_msr(32'h2);
      step((m % 2) != 0, ((m / 2) % 2) != 0, ((m / 4) % 2) != 0, ((m / 8) % 2) != 0);
      chk("R11 priority take", {31'h0, take}, 32'h1);
      chk("R11 priority cause", {30'h0, cause}, ec);
      if (ec == 0) begin e_esr = exp_esr(); e_ear = faddr; end
      chk("R8 priority ear", ear, e_ear);
    end

    // R9: nested memory fault
    set_msr(32'h0000_2202);
    faddr = 32'hDEAD_0000;
    step(1, 1, 0, 1);
    chk("R9 fatal raised", {31'h0, fatal}, 32'h1);
    chk("R9 nothing taken", {31'h0, take}, 32'h0);
    chk("R9 msr kept", msr, 32'h0000_2202);
    chk("R9 ear kept", ear, e_ear);
    chk("R9 esr kept", esr, e_esr);
    @(negedge clk);
    chk("R9 fatal single pulse", {31'h0, fatal}, 32'h0);

    // R12: core write loses against an entry, wins otherwise
    set_msr(32'h0000_0800);
    step(0, 1, 0, 0, 1'b1, 32'h0000_FFFF);
    chk("R12 write dropped on entry", msr, 32'h0000_1008);
    set_msr(32'h0000_1234);
    chk("R12 write applied", msr, 32'h0000_1234);

    finish_run();
  end

endmodule